// File: doc/BRIEF.md
# Indexed Display Register File

This block is the host-facing register file of a virtual display adapter. The host reaches it through a small group of 32-bit ports. It writes a register number into the index port, and then reads or writes the selected register through the value port. A third port, used for firmware access, reads as zero and ignores writes. Any other port offset reads as all ones.

The register set covers the following:
- a version-ID handshake;
- the display mode: width, height, and a fixed colour depth with its derived readbacks;
- the enable flag and the configuration-complete flag;
- a capability word;
- the cursor identifier, position and visibility;
- a one-cycle run request to the command processor, raised by a write to the sync register.

Two address windows sit above the plain registers. The colour-map window reads as zero and drops writes. The scratch window is backed by storage. Any other index counts as a bad access and sets a sticky error flag.

Value-port reads are registered. The read data appears with `rvalid_o` in the cycle after `rd_en_i`. Register writes take effect at the clock edge that samples them.

Top module: `disp_regfile`

## Requirements
- R1: Port offsets on `port_i`: 0 is the index port, which is written and read back; 1 is the value port; 2 is the firmware port, which reads 0 and ignores writes; 3 reads 0xFFFFFFFF. Read data is valid with `rvalid_o` one cycle after `rd_en_i`.
- R2: After reset the following hold: enable, config and cursor visibility are 0; the index is 0; the ID register (index 0) reads 0x90000002; width (index 2) reads 640; height (index 3) reads 480; the bad-access flag is 0.
- R3: A write to the ID register (index 0) is kept only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R4: A write to width (index 2) is kept only if it is at most 2368 (2360 rounded up to a 16-pixel granule). A write to height (index 3) is kept only if it is at most 1770.
- R5: With the configured 32-bit depth, the registers read as follows:
  - the depth register (index 6) reads 24;
  - bits-per-pixel (index 7) reads 32;
  - bytes-per-line (index 12) reads depth × width / 8.
- R6: Writing 1 to cursor-on (index 27) sets the visibility flag. Writing 0 clears it. Writing 2 or 3 leaves it unchanged. Cursor ID, X and Y (indices 24, 25, 26) store and read back any 32-bit value.
- R7: Indices 1024 to 1791 read 0. Writes to them change nothing, and they do not set the bad-access flag.
- R8: Indices from 1792 up to 1792 + SCRATCH_WORDS − 1 (64 by default) are read/write scratch words.
- R9: A value-port access to an index in 33..1023, or at or above the end of the scratch window, sets `bad_reg_o`. Such an access reads 0. The flag stays set until reset.
- R10: The capability register (index 17) reads 0x3 (fill and copy). When `hw_cursor_i` is high it also has bits 5, 6 and 7 set (0xE3).
- R11: Writes to the following registers drive outputs:
  - a write to enable (index 1) drives `enable_o` to (value ≠ 0);
  - a write to config-done (index 20) drives `config_o` to (value ≠ 0);
  - a write to sync (index 21) gives a one-cycle pulse on `sync_o` in the cycle after the write.
- R12: Max width (index 4) reads 2368 and max height (index 5) reads 1770. Every other index in 0..32 that is not listed here reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Port write strobe |
| rd_en_i | input | 1 | Port read strobe |
| port_i | input | 2 | Port offset: index, value, firmware, undecoded |
| wdata_i | input | 32 | Write data |
| hw_cursor_i | input | 1 | Hardware cursor available |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| enable_o | output | 1 | Adapter enable |
| config_o | output | 1 | Configuration complete, gates command processing |
| cursor_on_o | output | 1 | Cursor visible |
| sync_o | output | 1 | One-cycle run request to command processor |
| bad_reg_o | output | 1 | Sticky bad-register access flag |

## Verification
The bench writes to the mode registers at their limits and one step past them. A design with an off-by-one or missing range check would keep 2369 or 1771. It offers ID values that differ from the legal ones only in the low byte. A loose compare would accept 0x90000003. It drives the cursor-on codes 2 and 3 both while the flag is set and while it is clear. A design that decodes only bit 0 would toggle the flag. It touches the colour-map window, the last scratch word and the first index past it. Wrong window bounds would show up as a set bad flag, lost scratch data, or a missed error.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;
  localparam logic [31:0] ID_V0 = 32'h9000_0000;
  localparam logic [31:0] ID_V1 = 32'h9000_0001;
  localparam logic [31:0] ID_V2 = 32'h9000_0002;

  localparam logic [31:0] IX_ID       = 32'd0;
  localparam logic [31:0] IX_ENABLE   = 32'd1;
  localparam logic [31:0] IX_WIDTH    = 32'd2;
  localparam logic [31:0] IX_HEIGHT   = 32'd3;
  localparam logic [31:0] IX_MAXW     = 32'd4;
  localparam logic [31:0] IX_MAXH     = 32'd5;
  localparam logic [31:0] IX_DEPTH    = 32'd6;
  localparam logic [31:0] IX_BPP      = 32'd7;
  localparam logic [31:0] IX_PITCH    = 32'd12;
  localparam logic [31:0] IX_CAPS     = 32'd17;
  localparam logic [31:0] IX_CFGDONE  = 32'd20;
  localparam logic [31:0] IX_SYNC     = 32'd21;
  localparam logic [31:0] IX_CUR_ID   = 32'd24;
  localparam logic [31:0] IX_CUR_X    = 32'd25;
  localparam logic [31:0] IX_CUR_Y    = 32'd26;
  localparam logic [31:0] IX_CUR_ON   = 32'd27;
  localparam logic [31:0] IX_LAST_REG = 32'd32;
  localparam logic [31:0] PAL_BASE    = 32'd1024;
  localparam logic [31:0] PAL_END     = 32'd1792;
  localparam logic [31:0] SCR_BASE    = 32'd1792;

  localparam logic [31:0] CAP_BASIC  = 32'h0000_0003;
  localparam logic [31:0] CAP_CURSOR = 32'h0000_00E0;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_VALUE = 2'd1,
    PORT_FW    = 2'd2,
    PORT_NONE  = 2'd3
  } port_e;

  typedef enum logic [1:0] {WIN_REG, WIN_PAL, WIN_SCR, WIN_BAD} win_e;

  function automatic win_e classify(input logic [31:0] ix, input logic [31:0] scr_words);
    if (ix <= IX_LAST_REG) return WIN_REG;
    else if (ix >= PAL_BASE && ix < PAL_END) return WIN_PAL;
    else if (ix >= SCR_BASE && ix < SCR_BASE + scr_words) return WIN_SCR;
    else return WIN_BAD;
  endfunction
endpackage

// File: rtl/disp_port_if.sv
module disp_port_if
  import disp_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  port_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] value_rdata_i,
  output logic [31:0] index_o,
  output logic        val_wr_o,
  output logic        val_rd_o,
  output logic [31:0] rdata_o,
  output logic        rvalid_o
);
  logic [31:0] index_q, rdata_q;
  logic        rvalid_q;

  assign val_wr_o = wr_en_i && (port_e'(port_i) == PORT_VALUE);
  assign val_rd_o = rd_en_i && (port_e'(port_i) == PORT_VALUE);
  assign index_o  = index_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (wr_en_i && port_e'(port_i) == PORT_INDEX) index_q <= wdata_i;
      if (rd_en_i) begin
        unique case (port_e'(port_i))
          PORT_INDEX: rdata_q <= index_q;
          PORT_VALUE: rdata_q <= value_rdata_i;
          PORT_FW:    rdata_q <= '0;
          default:    rdata_q <= '1;
        endcase
      end
    end
  end

  p_undecoded_ones_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && port_i == 2'd3) |=> (rvalid_o && rdata_o == 32'hFFFF_FFFF));
  p_read_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
endmodule

// File: rtl/disp_cfg_regs.sv
module disp_cfg_regs
  import disp_regs_pkg::*;
#(
  parameter int unsigned MAX_W = 2368,
  parameter int unsigned MAX_H = 1770,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DEF_W = 640,
  parameter int unsigned DEF_H = 480
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] index_i,
  input  win_e        win_i,
  input  logic        val_wr_i,
  input  logic        val_rd_i,
  input  logic [31:0] wdata_i,
  input  logic        hw_cursor_i,
  output logic [31:0] rdata_o,
  output logic        enable_o,
  output logic        config_o,
  output logic        cursor_on_o,
  output logic        sync_o,
  output logic        bad_o
);
  localparam logic [31:0] MAX_W_L   = 32'(MAX_W);
  localparam logic [31:0] MAX_H_L   = 32'(MAX_H);
  localparam logic [31:0] DEPTH_L   = 32'(DEPTH);
  localparam logic [31:0] DEPTH_RPT = (DEPTH == 32) ? 32'd24 : DEPTH_L;

  logic [31:0] id_q, width_q, height_q, cur_id_q, cur_x_q, cur_y_q;
  logic        enable_q, config_q, cur_on_q, sync_q, bad_q;
  logic        wr_reg;

  assign wr_reg = val_wr_i && (win_i == WIN_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q     <= ID_V2;
      width_q  <= 32'(DEF_W);
      height_q <= 32'(DEF_H);
      cur_id_q <= '0;
      cur_x_q  <= '0;
      cur_y_q  <= '0;
      enable_q <= 1'b0;
      config_q <= 1'b0;
      cur_on_q <= 1'b0;
      sync_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      sync_q <= wr_reg && (index_i == IX_SYNC);
      if ((val_wr_i || val_rd_i) && win_i == WIN_BAD) bad_q <= 1'b1;
      if (wr_reg) begin
        case (index_i)
          IX_ID:      if (wdata_i == ID_V0 || wdata_i == ID_V1 || wdata_i == ID_V2) id_q <= wdata_i;
          IX_ENABLE:  enable_q <= |wdata_i;
          IX_WIDTH:   if (wdata_i <= MAX_W_L) width_q <= wdata_i;
          IX_HEIGHT:  if (wdata_i <= MAX_H_L) height_q <= wdata_i;
          IX_CFGDONE: config_q <= |wdata_i;
          IX_CUR_ID:  cur_id_q <= wdata_i;
          IX_CUR_X:   cur_x_q <= wdata_i;
          IX_CUR_Y:   cur_y_q <= wdata_i;
          IX_CUR_ON: begin
            if (wdata_i == 32'd1) cur_on_q <= 1'b1;
            else if (wdata_i == 32'd0) cur_on_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (win_i == WIN_REG) begin
      case (index_i)
        IX_ID:      rdata_o = id_q;
        IX_ENABLE:  rdata_o = {31'd0, enable_q};
        IX_WIDTH:   rdata_o = width_q;
        IX_HEIGHT:  rdata_o = height_q;
        IX_MAXW:    rdata_o = MAX_W_L;
        IX_MAXH:    rdata_o = MAX_H_L;
        IX_DEPTH:   rdata_o = DEPTH_RPT;
        IX_BPP:     rdata_o = DEPTH_L;
        IX_PITCH:   rdata_o = (DEPTH_L * width_q) >> 3;
        IX_CAPS:    rdata_o = CAP_BASIC | (hw_cursor_i ? CAP_CURSOR : 32'd0);
        IX_CFGDONE: rdata_o = {31'd0, config_q};
        IX_CUR_ID:  rdata_o = cur_id_q;
        IX_CUR_X:   rdata_o = cur_x_q;
        IX_CUR_Y:   rdata_o = cur_y_q;
        IX_CUR_ON:  rdata_o = {31'd0, cur_on_q};
        default:    rdata_o = '0;
      endcase
    end
  end

  assign enable_o    = enable_q;
  assign config_o    = config_q;
  assign cursor_on_o = cur_on_q;
  assign sync_o      = sync_q;
  assign bad_o       = bad_q;

  p_id_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_q[31:8] == 24'h90_0000 && id_q[7:0] <= 8'd2));
  p_width_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_q <= MAX_W_L && height_q <= MAX_H_L));
  p_cursor_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_reg && index_i == IX_CUR_ON && wdata_i > 32'd1) |=> $stable(cur_on_q));
  p_sync_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> $past(val_wr_i && index_i == IX_SYNC));
  p_bad_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |=> bad_q);
endmodule

// File: rtl/disp_scratch.sv
module disp_scratch #(
  parameter int unsigned WORDS = 64
) (
  input  logic        clk_i,
  input  logic        wr_i,
  input  logic [31:0] offs_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0] mem_q [WORDS];
  logic        in_range;
  logic [AW-1:0] addr;

  assign in_range = offs_i < 32'(WORDS);
  assign addr     = offs_i[AW-1:0];

  always_ff @(posedge clk_i) begin
    if (wr_i && in_range) mem_q[addr] <= wdata_i;
  end

  assign rdata_o = in_range ? mem_q[addr] : 32'd0;
endmodule

// File: rtl/disp_regfile.sv
module disp_regfile
  import disp_regs_pkg::*;
#(
  parameter int unsigned SCRATCH_WORDS = 64,
  parameter int unsigned WIDTH_RAW     = 2360,
  parameter int unsigned GRANULE       = 16,
  parameter int unsigned MAX_H         = 1770,
  parameter int unsigned DEPTH         = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  port_i,
  input  logic [31:0] wdata_i,
  input  logic        hw_cursor_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        enable_o,
  output logic        config_o,
  output logic        cursor_on_o,
  output logic        sync_o,
  output logic        bad_reg_o
);
  localparam int unsigned MAX_W = ((WIDTH_RAW + GRANULE - 1) / GRANULE) * GRANULE;

  logic [31:0] index, value_rdata, cfg_rdata, scr_rdata, scr_offs;
  logic        val_wr, val_rd;
  win_e        win;

  assign win      = classify(index, 32'(SCRATCH_WORDS));
  assign scr_offs = index - SCR_BASE;

  disp_port_if u_port (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .port_i, .wdata_i,
    .value_rdata_i(value_rdata), .index_o(index), .val_wr_o(val_wr),
    .val_rd_o(val_rd), .rdata_o, .rvalid_o
  );

  disp_cfg_regs #(.MAX_W(MAX_W), .MAX_H(MAX_H), .DEPTH(DEPTH)) u_cfg (
    .clk_i, .rst_ni, .index_i(index), .win_i(win), .val_wr_i(val_wr),
    .val_rd_i(val_rd), .wdata_i, .hw_cursor_i, .rdata_o(cfg_rdata),
    .enable_o, .config_o, .cursor_on_o, .sync_o, .bad_o(bad_reg_o)
  );

  disp_scratch #(.WORDS(SCRATCH_WORDS)) u_scr (
    .clk_i, .wr_i(val_wr && win == WIN_SCR), .offs_i(scr_offs),
    .wdata_i, .rdata_o(scr_rdata)
  );

  always_comb begin
    case (win)
      WIN_REG: value_rdata = cfg_rdata;
      WIN_SCR: value_rdata = scr_rdata;
      default: value_rdata = '0;
    endcase
  end

  p_pal_no_error_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bad_reg_o && (val_wr || val_rd) && win == WIN_PAL) |=> !bad_reg_o);
endmodule

// File: tb/disp_regfile_tb_top.sv
module disp_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, hw_cursor = 1'b0;
  logic [1:0]  port = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, enable, cfg, cur_on, sync, bad;
  int          tests = 0, fails = 0;

  typedef struct {logic [31:0] exp; string tag;} item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  disp_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .port_i(port),
    .wdata_i(wdata), .hw_cursor_i(hw_cursor), .rdata_o(rdata), .rvalid_o(rvalid),
    .enable_o(enable), .config_o(cfg), .cursor_on_o(cur_on), .sync_o(sync),
    .bad_reg_o(bad)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) chk(rdata, 32'hx, "R1 unexpected read");
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [1:0] p, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; port = p; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b1; port = p;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wreg(input logic [31:0] ix, input logic [31:0] v);
    wr(2'd0, ix); wr(2'd1, v);
  endtask

  task automatic rreg(input logic [31:0] ix, input logic [31:0] exp, input string tag);
    wr(2'd0, ix); rd(2'd1, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk({31'd0, enable}, 0, "R2 enable");
    chk({31'd0, cfg}, 0, "R2 config");
    chk({31'd0, cur_on}, 0, "R2 cursor");
    chk({31'd0, bad}, 0, "R2 bad");
    rd(2'd0, 32'd0, "R2 index");
    rd(2'd1, 32'h9000_0002, "R2 id");
    rreg(2, 640, "R2 width");
    rreg(3, 480, "R2 height");
    // R1 ports
    rd(2'd2, 32'd0, "R1 fw read");
    rd(2'd3, 32'hFFFF_FFFF, "R1 undecoded");
    wr(2'd0, 32'd25);
    wr(2'd2, 32'h55);
    rd(2'd0, 32'd25, "R1 index readback after fw write");
    // R3 ID negotiation
    wreg(0, 32'h9000_0001); rreg(0, 32'h9000_0001, "R3 accept v1");
    wreg(0, 32'h1234_5678); rreg(0, 32'h9000_0001, "R3 reject junk");
    wreg(0, 32'h9000_0003); rreg(0, 32'h9000_0001, "R3 reject v3");
    wreg(0, 32'h9000_0000); rreg(0, 32'h9000_0000, "R3 accept v0");
    // R4 mode limits
    wreg(2, 2368); rreg(2, 2368, "R4 width at max");
    wreg(2, 2369); rreg(2, 2368, "R4 width over max");
    wreg(2, 800);  rreg(2, 800, "R4 width 800");
    wreg(3, 1770); rreg(3, 1770, "R4 height at max");
    wreg(3, 1771); rreg(3, 1770, "R4 height over max");
    // R5 depth readbacks
    rreg(6, 24, "R5 depth");
    rreg(7, 32, "R5 bpp");
    rreg(12, 3200, "R5 pitch");
    // R12 fixed / unlisted
    rreg(4, 2368, "R12 max width");
    rreg(5, 1770, "R12 max height");
    wreg(9, 32'hABCD); rreg(9, 0, "R12 unlisted reads 0");
    // R6 cursor
    wreg(27, 1); chk({31'd0, cur_on}, 1, "R6 show");
    wreg(27, 2); chk({31'd0, cur_on}, 1, "R6 code2 keeps set");
    wreg(27, 3); chk({31'd0, cur_on}, 1, "R6 code3 keeps set");
    rreg(27, 1, "R6 readback on");
    wreg(27, 0); chk({31'd0, cur_on}, 0, "R6 hide");
    wreg(27, 3); chk({31'd0, cur_on}, 0, "R6 code3 keeps clear");
    wreg(27, 2); chk({31'd0, cur_on}, 0, "R6 code2 keeps clear");
    wreg(25, 32'hDEAD_0001); rreg(25, 32'hDEAD_0001, "R6 cursor x");
    wreg(26, 32'h0000_0077); rreg(26, 32'h77, "R6 cursor y");
    wreg(24, 32'h5); rreg(24, 32'h5, "R6 cursor id");
    // R7 palette
    wreg(1500, 32'hDEAD); rreg(1500, 0, "R7 palette read");
    rreg(1024, 0, "R7 palette low edge");
    rreg(1791, 0, "R7 palette high edge");
    chk({31'd0, bad}, 0, "R7 no error");
    // R8 scratch
    wreg(1792, 32'h1111_2222);
    wreg(1792 + 63, 32'h3333_4444);
    rreg(1792, 32'h1111_2222, "R8 scratch first");
    rreg(1792 + 63, 32'h3333_4444, "R8 scratch last");
    chk({31'd0, bad}, 0, "R8 no error");
    // R10 caps
    rreg(17, 32'h3, "R10 caps no cursor");
    hw_cursor = 1'b1;
    rreg(17, 32'hE3, "R10 caps cursor");
    // R11 enable/config/sync
    wreg(1, 5); chk({31'd0, enable}, 1, "R11 enable");
    rreg(1, 1, "R11 enable readback");
    wreg(20, 1); chk({31'd0, cfg}, 1, "R11 config");
    wreg(20, 0); chk({31'd0, cfg}, 0, "R11 config clear");
    chk({31'd0, sync}, 0, "R11 sync idle");
    wreg(21, 1); chk({31'd0, sync}, 1, "R11 sync pulse");
    @(posedge clk); #1;
    chk({31'd0, sync}, 0, "R11 sync one cycle");
    // R9 bad access
    rreg(1792 + 64, 0, "R9 past scratch reads 0");
    chk({31'd0, bad}, 1, "R9 bad set past scratch");
    rreg(1, 1, "R9 good read after bad");
    chk({31'd0, bad}, 1, "R9 bad sticky");
    rreg(40, 0, "R9 gap reads 0");
    chk({31'd0, bad}, 1, "R9 bad still set");
    repeat (4) @(negedge clk);
    chk(sb_q.size(), 0, "R1 all reads returned");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule